// File: doc/BRIEF.md
# Accumulator Execute Unit with Condition Flags

This block is the execute stage of a small single-accumulator processor. On each cycle in which the execute strobe is high it takes a 5-bit opcode and an already resolved 16-bit operand. It combines them with the accumulator it holds. At that clock edge it writes a new accumulator value and a new set of four condition flags: negative, zero, overflow and carry. Memory access, addressing, byte transfers and character or number I/O are handled elsewhere and reach this block only as a ready operand.

Each opcode has its own flag mask. A flag outside the mask keeps its value, so a later instruction can still test a condition that an earlier one set. Compare sets the flags exactly as subtract would but does not write the accumulator. Any opcode that this block does not implement changes neither the accumulator nor the flags.

Internally, a decoder turns the opcode into an operation kind: NONE, LOAD, ADD, SUB, AND, OR, NOT, ASL, ASR or CMP. The decoder also produces a flag mask and an accumulator write enable. A datapath with one shared adder computes the result and the candidate flags. The top level merges the candidate flags with the held flags bit by bit under the mask. There is no sequencing state: every strobed cycle is one complete operation, and the outputs change at the edge that samples the strobe.

Top module: `accx_unit`

## Requirements
- R1: While rst_n is low, and after reset is released, acc_out is 0 and flags_out is 0. The flags are packed as flags_out[3]=N, [2]=Z, [1]=V, [0]=C. N is result bit 15, and Z is 1 exactly when the 16-bit result is zero.
- R2: In a cycle with exec_in low, neither acc_out nor flags_out changes, whatever the opcode and operand.
- R3: Opcode 00001 (load) writes operand_in to the accumulator and updates N and Z. V and C are unchanged.
- R4: Opcode 00011 (add) writes acc+operand. C is the carry out of bit 15, and V is set on two's-complement signed overflow. N and Z are also updated.
- R5: Opcode 00100 (subtract) writes acc-operand, computed as acc + ~operand + 1. C is the carry out of that sum, so C=1 when there is no borrow. V marks signed overflow, and N and Z are also updated.
- R6: Opcodes 00101 (AND) and 00110 (OR) write the bitwise AND or OR of accumulator and operand. They update N and Z only; V and C keep their values.
- R7: Opcode 00111 (not) writes the bitwise inverse of the accumulator and ignores operand_in. It updates N and Z only.
- R8: Opcode 01000 (arithmetic shift left) shifts a zero into bit 0. C takes old bit 15, V is set when old bits 15 and 14 differ, and N and Z are also updated.
- R9: Opcode 01001 (arithmetic shift right) keeps bit 15 and shifts it down one place. C takes old bit 0, N and Z are updated, and V is never changed.
- R10: Opcode 10111 (compare) updates N, Z, V and C exactly as subtract would. The accumulator keeps its value.
- R11: Every other opcode, for example 00000, 01110 and 11111, leaves both the accumulator and the flags unchanged even with exec_in high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_in | input | 1 | Execute strobe; one operation per high cycle |
| opcode_in | input | 5 | Operation code |
| operand_in | input | 16 | Resolved operand |
| acc_out | output | 16 | Accumulator contents |
| flags_out | output | 4 | Condition flags {N,Z,V,C} |

## Verification
In every strobed cycle the accumulator write and the masked flag merge take effect at the same edge. The risky case is when one operation writes some flags while it must preserve a flag that an earlier operation set. The bench provokes this with back-to-back strobes: a signed-overflowing add sets V, and an arithmetic right shift follows at once. It also places AND/OR, not and load after carry-setting adds. The scoreboard then compares the whole flag vector in the following cycle, so V or C must survive untouched while N, Z and the accumulator change in that same edge.

// File: rtl/accx_pkg.sv
package accx_pkg;

    localparam int FLAG_N = 4;
    localparam int FIDX_N = 3;
    localparam int FIDX_Z = 2;
    localparam int FIDX_V = 1;
    localparam int FIDX_C = 0;

    localparam logic [4:0] OPC_LOAD = 5'b00001;
    localparam logic [4:0] OPC_ADD  = 5'b00011;
    localparam logic [4:0] OPC_SUB  = 5'b00100;
    localparam logic [4:0] OPC_AND  = 5'b00101;
    localparam logic [4:0] OPC_OR   = 5'b00110;
    localparam logic [4:0] OPC_NOT  = 5'b00111;
    localparam logic [4:0] OPC_ASL  = 5'b01000;
    localparam logic [4:0] OPC_ASR  = 5'b01001;
    localparam logic [4:0] OPC_CMP  = 5'b10111;

    localparam logic [FLAG_N-1:0] MSK_NZ   = 4'b1100;
    localparam logic [FLAG_N-1:0] MSK_NZC  = 4'b1101;
    localparam logic [FLAG_N-1:0] MSK_NZVC = 4'b1111;
    localparam logic [FLAG_N-1:0] MSK_NONE = 4'b0000;

    typedef enum logic [3:0] {
        K_NONE, K_LOAD, K_ADD, K_SUB, K_AND, K_OR, K_NOT, K_ASL, K_ASR, K_CMP
    } op_kind_e;

endpackage

// File: rtl/accx_decode.sv
module accx_decode
    import accx_pkg::*;
(
    input  logic [4:0]        opcode_i,
    output op_kind_e          kind_o,
    output logic [FLAG_N-1:0] mask_o,
    output logic              acc_we_o
);

    always_comb begin
        kind_o   = K_NONE;
        mask_o   = MSK_NONE;
        acc_we_o = 1'b0;
        unique case (opcode_i)
            OPC_LOAD: begin kind_o = K_LOAD; mask_o = MSK_NZ;   acc_we_o = 1'b1; end
            OPC_ADD:  begin kind_o = K_ADD;  mask_o = MSK_NZVC; acc_we_o = 1'b1; end
            OPC_SUB:  begin kind_o = K_SUB;  mask_o = MSK_NZVC; acc_we_o = 1'b1; end
            OPC_AND:  begin kind_o = K_AND;  mask_o = MSK_NZ;   acc_we_o = 1'b1; end
            OPC_OR:   begin kind_o = K_OR;   mask_o = MSK_NZ;   acc_we_o = 1'b1; end
            OPC_NOT:  begin kind_o = K_NOT;  mask_o = MSK_NZ;   acc_we_o = 1'b1; end
            OPC_ASL:  begin kind_o = K_ASL;  mask_o = MSK_NZVC; acc_we_o = 1'b1; end
            OPC_ASR:  begin kind_o = K_ASR;  mask_o = MSK_NZC;  acc_we_o = 1'b1; end
            OPC_CMP:  begin kind_o = K_CMP;  mask_o = MSK_NZVC; acc_we_o = 1'b0; end
            default:  begin kind_o = K_NONE; mask_o = MSK_NONE; acc_we_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/accx_datapath.sv
module accx_datapath
    import accx_pkg::*;
#(
    parameter int W = 16
) (
    input  op_kind_e          kind_i,
    input  logic [W-1:0]      acc_i,
    input  logic [W-1:0]      opnd_i,
    output logic [W-1:0]      res_o,
    output logic [FLAG_N-1:0] flg_o
);

    localparam int MSB = W - 1;

    logic         sub_sel;
    logic [W-1:0] b_eff;
    logic [W:0]   sum_w;
    logic         v_new;
    logic         c_new;

    assign sub_sel = (kind_i == K_SUB) || (kind_i == K_CMP);
    assign b_eff   = sub_sel ? ~opnd_i : opnd_i;
    assign sum_w   = {1'b0, acc_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_sel};

    always_comb begin
        res_o = acc_i;
        v_new = 1'b0;
        c_new = 1'b0;
        unique case (kind_i)
            K_LOAD: res_o = opnd_i;
            K_ADD, K_SUB, K_CMP: begin
                res_o = sum_w[W-1:0];
                c_new = sum_w[W];
                v_new = (acc_i[MSB] == b_eff[MSB]) && (sum_w[MSB] != acc_i[MSB]);
            end
            K_AND:  res_o = acc_i & opnd_i;
            K_OR:   res_o = acc_i | opnd_i;
            K_NOT:  res_o = ~acc_i;
            K_ASL: begin
                res_o = {acc_i[MSB-1:0], 1'b0};
                c_new = acc_i[MSB];
                v_new = acc_i[MSB] ^ acc_i[MSB-1];
            end
            K_ASR: begin
                res_o = {acc_i[MSB], acc_i[MSB:1]};
                c_new = acc_i[0];
            end
            default: res_o = acc_i;
        endcase
    end

    always_comb begin
        flg_o         = '0;
        flg_o[FIDX_N] = res_o[MSB];
        flg_o[FIDX_Z] = ~|res_o;
        flg_o[FIDX_V] = v_new;
        flg_o[FIDX_C] = c_new;
    end

endmodule

// File: rtl/accx_unit.sv
module accx_unit
    import accx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_in,
    input  logic [4:0]    opcode_in,
    input  logic [W-1:0]  operand_in,
    output logic [W-1:0]  acc_out,
    output logic [3:0]    flags_out
);

    op_kind_e          kind;
    logic [FLAG_N-1:0] mask;
    logic              acc_we;
    logic [W-1:0]      res;
    logic [FLAG_N-1:0] flg_new;
    logic [FLAG_N-1:0] flg_next;
    logic [W-1:0]      acc_q;
    logic [FLAG_N-1:0] flg_q;

    accx_decode u_dec (
        .opcode_i (opcode_in),
        .kind_o   (kind),
        .mask_o   (mask),
        .acc_we_o (acc_we)
    );

    accx_datapath #(.W(W)) u_dp (
        .kind_i (kind),
        .acc_i  (acc_q),
        .opnd_i (operand_in),
        .res_o  (res),
        .flg_o  (flg_new)
    );

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        assign flg_next[i] = mask[i] ? flg_new[i] : flg_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            flg_q <= '0;
        end else if (exec_in) begin
            if (acc_we) acc_q <= res;
            flg_q <= flg_next;
        end
    end

    assign acc_out   = acc_q;
    assign flags_out = flg_q;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_in |=> ($stable(acc_out) && $stable(flags_out)));

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_in && opcode_in == OPC_LOAD) |=>
            (acc_out == $past(operand_in)) && (flags_out[1:0] == $past(flags_out[1:0])));

    assert_logic_keep_vc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_in && (opcode_in == OPC_AND || opcode_in == OPC_OR)) |=>
            (flags_out[1:0] == $past(flags_out[1:0])));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_in && opcode_in == OPC_NOT) |=>
            (flags_out[2] == (acc_out == '0)) && (flags_out[3] == acc_out[W-1]));

    assert_asr_keeps_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_in && opcode_in == OPC_ASR) |=> (flags_out[1] == $past(flags_out[1])));

    assert_cmp_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_in && opcode_in == OPC_CMP) |=> $stable(acc_out));

    assert_unhandled_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_in && (opcode_in == 5'b00000 || opcode_in == 5'b11111)) |=>
            ($stable(acc_out) && $stable(flags_out)));

endmodule

// File: tb/accx_unit_tb.sv
module accx_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_in = 1'b0;
    logic [4:0]  opcode_in = '0;
    logic [15:0] operand_in = '0;
    logic [15:0] acc_out;
    logic [3:0]  flags_out;

    int     n_chk  = 0;
    int     n_fail = 0;
    longint cyc    = 0;

    typedef struct {
        logic [15:0] acc;
        logic [3:0]  flg;
        string       tag;
        longint      due;
    } item_t;

    item_t sb_q[$];

    logic [15:0] m_acc = '0;
    logic [3:0]  m_flg = '0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    accx_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_in    (exec_in),
        .opcode_in  (opcode_in),
        .operand_in (operand_in),
        .acc_out    (acc_out),
        .flags_out  (flags_out)
    );

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: acc/flags actual %h/%b expected %h/%b",
                     tag, act[19:4], act[3:0], exp[19:4], exp[3:0]);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(input logic ex, input logic [4:0] op, input logic [15:0] b);
        int          sa, sb, sr;
        int unsigned ua, ub;
        logic [15:0] r;
        logic [3:0]  msk;
        logic        v, c, wr;
        if (!ex) return;
        sa = int'($signed(m_acc)); sb = int'($signed(b));
        ua = int'(m_acc); ub = int'(b);
        r = m_acc; v = 1'b0; c = 1'b0; msk = 4'b0000; wr = 1'b1;
        case (op)
            5'b00001: begin r = b; msk = 4'b1100; end
            5'b00011: begin sr = sa + sb; r = m_acc + b; v = (sr > 32767) || (sr < -32768);
                            c = (ua + ub) > 65535; msk = 4'b1111; end
            5'b00100, 5'b10111: begin sr = sa - sb; r = m_acc - b;
                            v = (sr > 32767) || (sr < -32768); c = (ua >= ub); msk = 4'b1111;
                            wr = (op == 5'b00100); end
            5'b00101: begin r = m_acc & b; msk = 4'b1100; end
            5'b00110: begin r = m_acc | b; msk = 4'b1100; end
            5'b00111: begin r = ~m_acc; msk = 4'b1100; end
            5'b01000: begin r = m_acc << 1; c = m_acc[15]; v = (r[15] != m_acc[15]); msk = 4'b1111; end
            5'b01001: begin r = 16'($signed(m_acc) >>> 1); c = m_acc[0]; msk = 4'b1101; end
            default:  begin wr = 1'b0; end
        endcase
        for (int i = 0; i < 4; i++)
            if (msk[i]) m_flg[i] = (i == 3) ? r[15] : (i == 2) ? (r == 16'h0) : (i == 1) ? v : c;
        if (wr && msk != 4'b0000) m_acc = r;
    endtask

    // Driver: one operation per cycle, expected result pushed to the scoreboard
    task automatic drive(input string tag, input logic ex, input logic [4:0] op, input logic [15:0] b);
        item_t it;
        @(negedge clk);
        exec_in = ex; opcode_in = op; operand_in = b;
        model(ex, op, b);
        it.acc = m_acc; it.flg = m_flg; it.tag = tag; it.due = cyc + 1;
        sb_q.push_back(it);
    endtask

    // Monitor: compares one negedge after the sampling edge
    initial forever begin
        @(negedge clk);
        #1;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, {acc_out, flags_out}, {it.acc, it.flg});
        end
    end

    initial begin
        #1600000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {acc_out, flags_out}, 20'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {acc_out, flags_out}, 20'h0);

        drive("R3 load 7fff", 1, 5'b00001, 16'h7FFF);
        drive("R4 add overflow", 1, 5'b00011, 16'h0001);
        drive("R9 asr keeps V", 1, 5'b01001, 16'h1234);
        drive("R2 idle", 0, 5'b00011, 16'h5555);
        drive("R2 idle load", 0, 5'b00001, 16'h0000);
        drive("R3 load ffff", 1, 5'b00001, 16'hFFFF);
        drive("R4 add carry zero", 1, 5'b00011, 16'h0001);
        drive("R3 load keeps VC", 1, 5'b00001, 16'h00F0);
        drive("R6 and zero", 1, 5'b00101, 16'h0F0F);
        drive("R6 or neg", 1, 5'b00110, 16'h8001);
        drive("R7 not", 1, 5'b00111, 16'hFFFF);
        drive("R9 asr lsb", 1, 5'b01001, 16'h0000);
        drive("R3 load 8000", 1, 5'b00001, 16'h8000);
        drive("R5 sub overflow", 1, 5'b00100, 16'h0001);
        drive("R10 cmp equal", 1, 5'b10111, 16'h7FFF);
        drive("R10 cmp less", 1, 5'b10111, 16'h8000);
        drive("R5 sub borrow", 1, 5'b00100, 16'hFFFF);
        drive("R3 load 4000", 1, 5'b00001, 16'h4000);
        drive("R8 asl overflow", 1, 5'b01000, 16'h0000);
        drive("R8 asl carry zero", 1, 5'b01000, 16'h0000);
        drive("R11 op 00000", 1, 5'b00000, 16'h1111);
        drive("R11 op 01110", 1, 5'b01110, 16'h2222);
        drive("R11 op 11111", 1, 5'b11111, 16'h3333);
        drive("R3 load 8001", 1, 5'b00001, 16'h8001);
        drive("R9 asr negative", 1, 5'b01001, 16'h0000);
        drive("R8 asl neg", 1, 5'b01000, 16'h0000);
        drive("R7 not zero", 1, 5'b00111, 16'h0000);
        for (int k = 0; k < 40; k++)
            drive("R4 R5 R6 mixed", 1, (k % 3 == 0) ? 5'b00011 : (k % 3 == 1) ? 5'b00100 : 5'b00110,
                  16'(k * 16'h1357 + 16'h0ACE));
        drive("R2 tail idle", 0, 5'b00001, 16'hDEAD);
        @(negedge clk);
        exec_in = 1'b0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule